// File: doc/BRIEF.md
# Core Power Domain Sequencer

This controller steps a processor core power domain, and an optional vector-unit domain beside it, through an ordered power-down and power-up. The debug and trace domain is never switched, so a debugger can keep using it while the core is off. The block drives the power switch enables, the output clamps, the three active-low resets and a debug power-down request. It reports a busy level and a one-cycle done pulse.

On power-down, the block first warns the debug logic and waits for the acknowledge. It then holds every reset for a programmable minimum time, clamps the core and vector outputs, and only after that removes power. On power-up, it enables the switches while the resets and clamps are still held, and waits a settle time for the supply to ramp. It then releases the clamps, drops the debug request without waiting for the acknowledge to fall, and releases the resets one at a time. A flag that is sampled with the power-up command can leave the vector domain unpowered, clamped and in reset while the core runs.

Top module: `core_pwr_seq`

## Requirements
- R1: After a synchronous system reset, all of the following hold: both power enables are 1, both clamps are 0, `por_n`, `core_rst_n` and `vec_rst_n` are 1, `dbg_req` is 0, `busy` is 0 and `done` is 0.
- R2: A `pd_cmd` pulse accepted while powered raises `dbg_req` and `busy` one cycle later. All resets, clamps and power enables stay unchanged until `dbg_ack` is seen high.
- R3: The cycle after `dbg_ack` is seen, `por_n`, `core_rst_n` and `vec_rst_n` are all 0. They stay 0 for exactly RST_HOLD cycles (default 8) while both clamps are still 0.
- R4: `core_clamp` and `vec_clamp` are then 1 together with power still on. One cycle later both power enables are 0.
- R5: A `pu_cmd` accepted while off sets `core_pwr_en` to 1 the next cycle while all resets stay 0 and both clamps stay 1. This state is held for exactly SETTLE cycles (default 16).
- R6: After the settle time, the clamps are released. One cycle later `dbg_req` falls even while `dbg_ack` is still 1.
- R7: After `dbg_req` falls, the resets are released one per cycle: `por_n` first, then `core_rst_n`, then `vec_rst_n` if the vector domain was selected.
- R8: If `vec_en` is 0 when `pu_cmd` is accepted, the vector domain is left alone for the whole power-up: `vec_pwr_en` stays 0, `vec_clamp` stays 1 and `vec_rst_n` stays 0. `core_clamp` is still released.
- R9: Commands are ignored in some cases, and the outputs do not change. This covers `pu_cmd` while powered, `pd_cmd` while off, and any command during a sequence.
- R10: `done` is a one-cycle pulse. It occurs in the first cycle of the powered-off or fully-on state, and `busy` is 0 from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_cmd | input | 1 | Power-down command pulse |
| pu_cmd | input | 1 | Power-up command pulse |
| vec_en | input | 1 | Power the vector domain on power-up; sampled with `pu_cmd` |
| dbg_ack | input | 1 | Debug power-down acknowledge |
| dbg_req | output | 1 | Debug power-down request |
| por_n | output | 1 | Power-on reset, active low |
| core_rst_n | output | 1 | Core reset, active low |
| vec_rst_n | output | 1 | Vector reset, active low |
| core_clamp | output | 1 | Core output clamp enable |
| vec_clamp | output | 1 | Vector output clamp enable |
| core_pwr_en | output | 1 | Core domain power switch enable |
| vec_pwr_en | output | 1 | Vector domain power switch enable |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The power-down sequence is swept over acknowledge delays from zero to four cycles. A zero delay shows whether the block skips the handshake state, and longer delays show whether anything moves before the acknowledge. On odd delays, contrary commands are driven during the wait.

Each power-down is followed by a power-up with the vector flag both set and clear. This separates the full release order from the core-only path, where the vector outputs must never move. The acknowledge is kept high through power-up to show that the debug request falls without waiting for it.

Lone commands in the wrong resting state confirm that nothing starts. Cycle counts of the reset hold and the settle time are measured against the parameters.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [3:0] {
    ST_ON,
    ST_PD_REQ,
    ST_PD_RST,
    ST_PD_CLAMP,
    ST_OFF,
    ST_PU_PWR,
    ST_PU_UNCLAMP,
    ST_PU_DBG,
    ST_PU_POR,
    ST_PU_CORE,
    ST_PU_VEC
  } cps_state_e;

  typedef struct packed {
    logic dbg_req;
    logic por_n;
    logic core_rst_n;
    logic vec_rst_n;
    logic core_clamp;
    logic vec_clamp;
    logic core_pwr_en;
    logic vec_pwr_en;
  } cps_out_t;

  function automatic logic cps_terminal(input cps_state_e s);
    return (s == ST_ON) || (s == ST_OFF);
  endfunction

  // Output pattern of each state; vl says whether the vector domain is live
  function automatic cps_out_t cps_decode(input cps_state_e s, input logic vl);
    cps_out_t o;
    o.dbg_req     = 1'b1;
    o.por_n       = 1'b0;
    o.core_rst_n  = 1'b0;
    o.vec_rst_n   = 1'b0;
    o.core_clamp  = 1'b1;
    o.vec_clamp   = 1'b1;
    o.core_pwr_en = 1'b1;
    o.vec_pwr_en  = vl;
    case (s)
      ST_ON, ST_PD_REQ: begin
        o.dbg_req    = (s == ST_PD_REQ);
        o.por_n      = 1'b1;
        o.core_rst_n = 1'b1;
        o.vec_rst_n  = vl;
        o.core_clamp = 1'b0;
        o.vec_clamp  = !vl;
      end
      ST_PD_RST: begin
        o.core_clamp = 1'b0;
        o.vec_clamp  = !vl;
      end
      ST_PD_CLAMP, ST_PU_PWR: ;
      ST_OFF: begin
        o.core_pwr_en = 1'b0;
        o.vec_pwr_en  = 1'b0;
      end
      ST_PU_UNCLAMP, ST_PU_DBG, ST_PU_POR, ST_PU_CORE, ST_PU_VEC: begin
        o.core_clamp = 1'b0;
        o.vec_clamp  = !vl;
        o.dbg_req    = (s == ST_PU_UNCLAMP);
        o.por_n      = (s != ST_PU_UNCLAMP) && (s != ST_PU_DBG);
        o.core_rst_n = (s == ST_PU_CORE) || (s == ST_PU_VEC);
        o.vec_rst_n  = (s == ST_PU_VEC);
      end
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/cps_timer.sv
module cps_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
  import cps_pkg::*;
#(
  parameter int RST_HOLD = 8,
  parameter int SETTLE   = 16,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pd_cmd,
  input  logic          pu_cmd,
  input  logic          vec_en,
  input  logic          dbg_ack,
  input  logic          tmr_zero,
  output cps_state_e    state_q,
  output cps_state_e    state_d,
  output logic          vl_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  localparam logic [CW-1:0] HOLD_LD   = CW'(RST_HOLD - 1);
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE - 1);

  logic vl_q;

  always_comb begin
    state_d = state_q;
    vl_d    = vl_q;
    case (state_q)
      ST_ON:         if (pd_cmd) state_d = ST_PD_REQ;
      ST_PD_REQ:     if (dbg_ack) state_d = ST_PD_RST;
      ST_PD_RST:     if (tmr_zero) state_d = ST_PD_CLAMP;
      ST_PD_CLAMP:   state_d = ST_OFF;
      ST_OFF: begin
        if (pu_cmd) begin
          state_d = ST_PU_PWR;
          vl_d    = vec_en;
        end
      end
      ST_PU_PWR:     if (tmr_zero) state_d = ST_PU_UNCLAMP;
      ST_PU_UNCLAMP: state_d = ST_PU_DBG;
      ST_PU_DBG:     state_d = ST_PU_POR;
      ST_PU_POR:     state_d = ST_PU_CORE;
      ST_PU_CORE:    state_d = vl_q ? ST_PU_VEC : ST_ON;
      ST_PU_VEC:     state_d = ST_ON;
      default:       state_d = ST_ON;
    endcase
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = HOLD_LD;
    if (state_d == ST_PD_RST && state_q != ST_PD_RST) begin
      tmr_load = 1'b1;
    end else if (state_d == ST_PU_PWR && state_q != ST_PU_PWR) begin
      tmr_load = 1'b1;
      tmr_val  = SETTLE_LD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ON;
      vl_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      vl_q    <= vl_d;
    end
  end

endmodule

// File: rtl/cps_outreg.sv
module cps_outreg
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cps_state_e state_q,
  input  cps_state_e state_d,
  input  logic       vl_d,
  output cps_out_t   out_q,
  output logic       busy_q,
  output logic       done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= cps_decode(ST_ON, 1'b1);
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      out_q  <= cps_decode(state_d, vl_d);
      busy_q <= !cps_terminal(state_d);
      done_q <= cps_terminal(state_d) && !cps_terminal(state_q);
    end
  end

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cps_pkg::*;
#(
  parameter int RST_HOLD = 8,
  parameter int SETTLE   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_cmd,
  input  logic pu_cmd,
  input  logic vec_en,
  input  logic dbg_ack,
  output logic dbg_req,
  output logic por_n,
  output logic core_rst_n,
  output logic vec_rst_n,
  output logic core_clamp,
  output logic vec_clamp,
  output logic core_pwr_en,
  output logic vec_pwr_en,
  output logic busy,
  output logic done
);

  localparam int MAXC = (RST_HOLD > SETTLE) ? RST_HOLD : SETTLE;
  localparam int CW   = $clog2(MAXC + 1);

  cps_state_e    state_q, state_d;
  logic          vl_d, tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  cps_out_t      out_q;

  cps_fsm #(.RST_HOLD(RST_HOLD), .SETTLE(SETTLE), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .pd_cmd(pd_cmd), .pu_cmd(pu_cmd), .vec_en(vec_en),
    .dbg_ack(dbg_ack), .tmr_zero(tmr_zero), .state_q(state_q), .state_d(state_d),
    .vl_d(vl_d), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  cps_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  cps_outreg u_out (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d), .vl_d(vl_d),
    .out_q(out_q), .busy_q(busy), .done_q(done)
  );

  assign dbg_req     = out_q.dbg_req;
  assign por_n       = out_q.por_n;
  assign core_rst_n  = out_q.core_rst_n;
  assign vec_rst_n   = out_q.vec_rst_n;
  assign core_clamp  = out_q.core_clamp;
  assign vec_clamp   = out_q.vec_clamp;
  assign core_pwr_en = out_q.core_pwr_en;
  assign vec_pwr_en  = out_q.vec_pwr_en;

endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
  parameter int RST_HOLD = 8,
  parameter int SETTLE   = 16
) (
  input logic clk,
  input logic rst,
  input logic dbg_ack,
  input logic dbg_req,
  input logic por_n,
  input logic core_rst_n,
  input logic vec_rst_n,
  input logic core_clamp,
  input logic vec_clamp,
  input logic core_pwr_en,
  input logic vec_pwr_en,
  input logic busy,
  input logic done
);

  localparam int HW = $clog2(RST_HOLD + 2) + 1;
  localparam int SW = $clog2(SETTLE + 2) + 1;

  logic [HW-1:0] low_cnt;
  logic [SW-1:0] pwr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      pwr_cnt <= '0;
    end else begin
      if (por_n) low_cnt <= '0;
      else if (low_cnt < HW'(RST_HOLD)) low_cnt <= low_cnt + 1'b1;
      if (!core_pwr_en) pwr_cnt <= '0;
      else if (pwr_cnt < SW'(SETTLE)) pwr_cnt <= pwr_cnt + 1'b1;
    end
  end

  // R2
  ack_before_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(por_n) |-> dbg_req && $past(dbg_ack));

  // R3
  reset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_clamp) |-> !por_n && low_cnt >= HW'(RST_HOLD));

  // R4
  clamps_together_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_clamp) |-> vec_clamp);

  // R4
  clamp_before_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_pwr_en) |-> core_clamp && vec_clamp && $past(core_clamp));

  // R5
  settle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_clamp) |-> core_pwr_en && !por_n && pwr_cnt >= SW'(SETTLE));

  // R7
  core_release_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst_n) |-> por_n && !dbg_req && !core_clamp);

  // R7
  vec_release_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_rst_n) |-> $past(core_rst_n) && vec_pwr_en);

  // R8
  vec_off_safe_chk: assert property (@(posedge clk) disable iff (rst)
    !vec_pwr_en |-> vec_clamp && !vec_rst_n);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy ##1 !done);

endmodule

bind core_pwr_seq cps_chk #(.RST_HOLD(RST_HOLD), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst(rst), .dbg_ack(dbg_ack), .dbg_req(dbg_req), .por_n(por_n),
  .core_rst_n(core_rst_n), .vec_rst_n(vec_rst_n), .core_clamp(core_clamp),
  .vec_clamp(vec_clamp), .core_pwr_en(core_pwr_en), .vec_pwr_en(vec_pwr_en),
  .busy(busy), .done(done)
);

// File: tb/core_pwr_seq_test.sv
module core_pwr_seq_test;

  localparam int HOLD = 8;
  localparam int SETL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_cmd = 1'b0, pu_cmd = 1'b0, vec_en = 1'b1, dbg_ack = 1'b0;
  logic dbg_req, por_n, core_rst_n, vec_rst_n, core_clamp, vec_clamp;
  logic core_pwr_en, vec_pwr_en, busy, done;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  core_pwr_seq #(.RST_HOLD(HOLD), .SETTLE(SETL)) uut (
    .clk(clk), .rst(rst), .pd_cmd(pd_cmd), .pu_cmd(pu_cmd), .vec_en(vec_en),
    .dbg_ack(dbg_ack), .dbg_req(dbg_req), .por_n(por_n), .core_rst_n(core_rst_n),
    .vec_rst_n(vec_rst_n), .core_clamp(core_clamp), .vec_clamp(vec_clamp),
    .core_pwr_en(core_pwr_en), .vec_pwr_en(vec_pwr_en), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic power_down(input int ack_delay, input bit spam);
    int n;
    step(); pd_cmd = 1'b1;
    step(); pd_cmd = 1'b0;
    chk("R2", "dbg_req raised", dbg_req, 1);
    chk("R2", "busy raised", busy, 1);
    chk("R2", "por_n before ack", por_n, 1);
    for (int i = 0; i < ack_delay; i++) begin
      if (spam) begin pu_cmd = 1'b1; pd_cmd = 1'b1; end
      step();
      chk("R2", "core_rst_n waits for ack", core_rst_n, 1);
      chk("R9", "no clamp from spam", core_clamp, 0);
      chk("R9", "still busy", busy, 1);
    end
    pu_cmd = 1'b0; pd_cmd = 1'b0;
    dbg_ack = 1'b1;
    step();
    chk("R3", "resets low after ack", {por_n, core_rst_n, vec_rst_n}, 0);
    chk("R3", "no clamp yet", core_clamp, 0);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      step();
      if (!core_clamp) n++; else break;
    end
    chk("R3", "reset hold cycles", n, HOLD);
    chk("R4", "both clamps", {core_clamp, vec_clamp}, 3);
    chk("R4", "core power during clamp", core_pwr_en, 1);
    step();
    chk("R4", "power removed", {core_pwr_en, vec_pwr_en}, 0);
    chk("R10", "done at off", done, 1);
    chk("R10", "busy at off", busy, 0);
    step();
    chk("R10", "done single pulse", done, 0);
    dbg_ack = 1'b0;
  endtask

  task automatic power_up(input bit vsel);
    int n;
    dbg_ack = 1'b1;
    step(); vec_en = vsel; pu_cmd = 1'b1;
    step(); pu_cmd = 1'b0; vec_en = !vsel;
    chk("R5", "core power on", core_pwr_en, 1);
    chk("R8", "vec power follows flag", vec_pwr_en, vsel);
    chk("R5", "resets held", {por_n, core_rst_n, vec_rst_n}, 0);
    chk("R5", "clamps held", {core_clamp, vec_clamp}, 3);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      step();
      if (core_clamp) n++; else break;
    end
    chk("R5", "settle cycles", n, SETL);
    chk("R8", "vec clamp", vec_clamp, !vsel);
    chk("R6", "dbg_req during unclamp", dbg_req, 1);
    step();
    chk("R6", "dbg_req falls with ack high", dbg_req, 0);
    chk("R7", "por_n not yet", por_n, 0);
    step();
    chk("R7", "por_n first", {por_n, core_rst_n}, 2);
    step();
    chk("R7", "core_rst_n second", {core_rst_n, vec_rst_n}, 2);
    dbg_ack = 1'b0;
    if (vsel) begin
      step();
      chk("R7", "vec_rst_n third", vec_rst_n, 1);
      chk("R10", "no done before last release", done, 0);
    end
    step();
    chk("R10", "done at on", done, 1);
    chk("R10", "busy at on", busy, 0);
    chk("R8", "vec outputs final", {vec_pwr_en, vec_clamp, vec_rst_n}, vsel ? 5 : 2);
    step();
    chk("R10", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R1", "power enables", {core_pwr_en, vec_pwr_en}, 3);
    chk("R1", "clamps", {core_clamp, vec_clamp}, 0);
    chk("R1", "resets", {por_n, core_rst_n, vec_rst_n}, 7);
    chk("R1", "dbg/busy/done", {dbg_req, busy, done}, 0);
    // pu_cmd while powered: ignored
    pu_cmd = 1'b1; step(); pu_cmd = 1'b0;
    repeat (3) begin
      step();
      chk("R9", "pu_cmd ignored when on", {busy, dbg_req, por_n, core_clamp}, 2);
    end
    for (int d = 0; d < 5; d++) begin
      for (int v = 0; v < 2; v++) begin
        power_down(d, d[0]);
        if (d == 2 && v == 0) begin
          pd_cmd = 1'b1; step(); pd_cmd = 1'b0;
          repeat (3) begin
            step();
            chk("R9", "pd_cmd ignored when off",
                {busy, dbg_req, core_pwr_en, core_clamp}, 5);
          end
        end
        power_up(v[0]);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule